// File: doc/BRIEF.md
# Fractional-Period Time-of-Day Counter

This block keeps a free-running time of day that advances once per reference clock. The amount it advances is a programmable period made of a whole number of nanoseconds plus a fraction expressed as numerator over denominator. The fraction is handled with a remainder accumulator, so over many cycles the average advance matches the exact period, even when a single cycle can only add whole nanoseconds. Time is held as a 30-bit nanosecond field that wraps at one billion, plus a 48-bit seconds count.

Software reaches the block through a plain register port with write and read strobes. New values for the period, for an absolute time load, and for a signed step offset are first written to staging registers. Each group takes effect only when its own go register is written. Period values that cannot be applied are refused and an error output is raised. Reading the nanosecond register also captures the seconds count, so that the two seconds registers read afterwards belong to the same instant. The live time is also driven continuously on output buses for local timestamp logic.

Top module: `frac_tod_counter`

## Requirements
- R1: After reset, time_ns and time_sec are 0, cfg_err is 0, and the active period is RESET_QUO whole nanoseconds with no fraction (numerator 0, denominator 1).
- R2: On each clock the time advances by the whole-nanosecond count plus one extra nanosecond whenever the remainder accumulator plus the numerator reaches or exceeds the denominator. In that case the accumulator keeps the sum minus the denominator; otherwise it keeps the sum.
- R3: Writes to address 0 (whole ns), 1 (numerator) and 2 (denominator) change nothing until a write to address 3 with bit 0 set. A write to address 3 with bit 0 clear is ignored. A valid commit loads all three values and clears the accumulator. The new period governs every advance from the next clock on.
- R4: A period commit whose staged denominator is 0, or whose numerator is not below the denominator, leaves the active period unchanged and sets cfg_err. The next valid commit clears cfg_err.
- R5: Nanoseconds wrap at 1,000,000,000 and carry into the seconds. A result below zero borrows from the seconds. Seconds wrap modulo 2^48 in both directions.
- R6: Addresses 4 (nanoseconds), 5 (upper 16 seconds bits) and 6 (lower 32 seconds bits) are staged. A write to address 7 with bit 0 set loads all three together in one clock, replacing the time with no advance in that clock.
- R7: Address 8 holds a step offset: bit 31 is the sign (1 = subtract) and bits 29:0 are the magnitude in ns. A write to address 9 with bit 0 set makes the next time equal to the time plus the period increment plus or minus the magnitude, normalised with carries or borrows of up to two seconds.
- R8: A read strobe returns data on reg_rdata in the following cycle. Address 10 returns the nanoseconds and captures the seconds. Addresses 11 and 12 return the upper 16 and lower 32 bits of that captured value. Every other address reads as 0.
- R9: time_ns and time_sec always show the current time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after reg_rd |
| cfg_err | output | 1 | Last period commit was refused |
| time_ns | output | 30 | Current nanoseconds |
| time_sec | output | 48 | Current seconds |

## Verification
A go write captured at a rising edge changes time_ns and time_sec at that same edge, so the new time is visible from the next falling edge. A new period first changes the advance one edge later. cfg_err follows at the commit edge. Read data appears on reg_rdata at the edge that samples reg_rd. The bench drives inputs on falling edges and steps a behavioural model on rising edges in the order these latencies imply. At every falling edge it compares the time buses and cfg_err, and it compares reg_rdata only in the cycle after a read.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_PER_WHOLE = 4'd0,
    A_PER_NUM   = 4'd1,
    A_PER_DEN   = 4'd2,
    A_PER_GO    = 4'd3,
    A_SET_NS    = 4'd4,
    A_SET_SHI   = 4'd5,
    A_SET_SLO   = 4'd6,
    A_SET_GO    = 4'd7,
    A_STEP      = 4'd8,
    A_STEP_GO   = 4'd9,
    A_RD_NS     = 4'd10,
    A_RD_SHI    = 4'd11,
    A_RD_SLO    = 4'd12
  } reg_addr_e;
endpackage

// File: rtl/tod_regfile.sv
module tod_regfile
  import tod_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int QUO_W     = 8,
  parameter int FRAC_W    = 32,
  parameter int NS_W      = 30,
  parameter int SEC_W     = 48,
  parameter int RESET_QUO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [NS_W-1:0]   time_ns,
  input  logic [SEC_W-1:0]  time_sec,
  output logic              per_go,
  output logic              set_go,
  output logic              step_go,
  output logic [QUO_W-1:0]  stg_quo,
  output logic [FRAC_W-1:0] stg_num,
  output logic [FRAC_W-1:0] stg_den,
  output logic [NS_W-1:0]   stg_ns,
  output logic [SEC_W-1:0]  stg_sec,
  output logic              stg_neg,
  output logic [NS_W-1:0]   stg_mag,
  output logic [DATA_W-1:0] rdata
);
  localparam int SEC_HI_W = SEC_W - DATA_W;

  logic [SEC_W-1:0] snap_sec;

  assign per_go  = wr_en && (addr == A_PER_GO)  && wdata[0];
  assign set_go  = wr_en && (addr == A_SET_GO)  && wdata[0];
  assign step_go = wr_en && (addr == A_STEP_GO) && wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_quo <= QUO_W'(RESET_QUO);
      stg_num <= '0;
      stg_den <= FRAC_W'(1);
      stg_ns  <= '0;
      stg_sec <= '0;
      stg_neg <= 1'b0;
      stg_mag <= '0;
    end else if (wr_en) begin
      case (addr)
        A_PER_WHOLE: stg_quo <= wdata[QUO_W-1:0];
        A_PER_NUM:   stg_num <= wdata[FRAC_W-1:0];
        A_PER_DEN:   stg_den <= wdata[FRAC_W-1:0];
        A_SET_NS:    stg_ns  <= wdata[NS_W-1:0];
        A_SET_SHI:   stg_sec[SEC_W-1:DATA_W] <= wdata[SEC_HI_W-1:0];
        A_SET_SLO:   stg_sec[DATA_W-1:0]     <= wdata;
        A_STEP: begin
          stg_neg <= wdata[DATA_W-1];
          stg_mag <= wdata[NS_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // Registered read path; a nanosecond read freezes the seconds for later reads.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      snap_sec <= '0;
    end else if (rd_en) begin
      case (addr)
        A_RD_NS: begin
          rdata    <= {{(DATA_W-NS_W){1'b0}}, time_ns};
          snap_sec <= time_sec;
        end
        A_RD_SHI: rdata <= {{(DATA_W-SEC_HI_W){1'b0}}, snap_sec[SEC_W-1:DATA_W]};
        A_RD_SLO: rdata <= snap_sec[DATA_W-1:0];
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tod_period_unit.sv
module tod_period_unit #(
  parameter int QUO_W     = 8,
  parameter int FRAC_W    = 32,
  parameter int RESET_QUO = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_go,
  input  logic [QUO_W-1:0]  stg_quo,
  input  logic [FRAC_W-1:0] stg_num,
  input  logic [FRAC_W-1:0] stg_den,
  output logic [QUO_W:0]    inc,
  output logic              cfg_err
);
  logic [QUO_W-1:0]  quo_a;
  logic [FRAC_W-1:0] num_a, den_a, acc;
  logic [FRAC_W:0]   acc_sum;
  logic              extra_ns;
  logic              commit_ok, commit_bad;

  // Named events for the checks below.
  assign commit_ok  = per_go && (stg_den != '0) && (stg_num < stg_den);
  assign commit_bad = per_go && !commit_ok;

  assign acc_sum  = {1'b0, acc} + {1'b0, num_a};
  assign extra_ns = acc_sum >= {1'b0, den_a};
  assign inc      = {1'b0, quo_a} + (QUO_W+1)'(extra_ns);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quo_a   <= QUO_W'(RESET_QUO);
      num_a   <= '0;
      den_a   <= FRAC_W'(1);
      acc     <= '0;
      cfg_err <= 1'b0;
    end else if (commit_ok) begin
      quo_a   <= stg_quo;
      num_a   <= stg_num;
      den_a   <= stg_den;
      acc     <= '0;
      cfg_err <= 1'b0;
    end else begin
      acc <= extra_ns ? FRAC_W'(acc_sum - {1'b0, den_a}) : acc_sum[FRAC_W-1:0];
      if (commit_bad) cfg_err <= 1'b1;
    end
  end

  a_r4_bad_commit_flags: assert property (@(posedge clk) disable iff (!rst_n)
    commit_bad |=> cfg_err);
  a_r4_bad_commit_keeps_period: assert property (@(posedge clk) disable iff (!rst_n)
    commit_bad |=> $stable({quo_a, num_a, den_a}));
  a_r4_good_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    commit_ok |=> !cfg_err);
  a_r2_acc_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    acc < den_a);
endmodule

// File: rtl/tod_time_core.sv
module tod_time_core #(
  parameter int QUO_W      = 8,
  parameter int NS_W       = 30,
  parameter int SEC_W      = 48,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [QUO_W:0]   inc,
  input  logic             set_go,
  input  logic [NS_W-1:0]  stg_ns,
  input  logic [SEC_W-1:0] stg_sec,
  input  logic             step_go,
  input  logic             stg_neg,
  input  logic [NS_W-1:0]  stg_mag,
  output logic [NS_W-1:0]  time_ns,
  output logic [SEC_W-1:0] time_sec
);
  localparam int SW = NS_W + 4;
  localparam logic signed [SW-1:0] ONE_S = SW'(longint'(NS_PER_SEC));
  localparam logic signed [SW-1:0] TWO_S = SW'(2 * longint'(NS_PER_SEC));

  // Fold a signed nanosecond sum back into range; returns {carry[2:0], ns}.
  function automatic logic [NS_W+2:0] normalize(input logic signed [SW-1:0] v);
    logic signed [SW-1:0] r;
    logic signed [2:0]    c;
    if (v >= TWO_S) begin
      r = v - TWO_S; c = 3'sd2;
    end else if (v >= ONE_S) begin
      r = v - ONE_S; c = 3'sd1;
    end else if (!v[SW-1]) begin
      r = v;         c = 3'sd0;
    end else if (v >= -ONE_S) begin
      r = v + ONE_S; c = -3'sd1;
    end else begin
      r = v + TWO_S; c = -3'sd2;
    end
    return {c, r[NS_W-1:0]};
  endfunction

  logic signed [SW-1:0] ns_x, inc_x, mag_x, step_x, sum_x;
  logic [NS_W+2:0]      norm;
  logic [2:0]           sec_carry;
  logic [NS_W-1:0]      ns_next;
  logic [SEC_W-1:0]     sec_next;

  assign ns_x   = $signed({{(SW-NS_W){1'b0}}, time_ns});
  assign inc_x  = $signed({{(SW-QUO_W-1){1'b0}}, inc});
  assign mag_x  = $signed({{(SW-NS_W){1'b0}}, stg_mag});
  assign step_x = !step_go ? '0 : (stg_neg ? -mag_x : mag_x);
  assign sum_x  = ns_x + inc_x + step_x;

  assign norm      = normalize(sum_x);
  assign sec_carry = norm[NS_W+2:NS_W];
  assign ns_next   = norm[NS_W-1:0];
  assign sec_next  = time_sec + {{(SEC_W-3){sec_carry[2]}}, sec_carry};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_ns  <= '0;
      time_sec <= '0;
    end else if (set_go) begin
      time_ns  <= stg_ns;
      time_sec <= stg_sec;
    end else begin
      time_ns  <= ns_next;
      time_sec <= sec_next;
    end
  end

  a_r5_ns_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(set_go) |-> (time_ns < NS_W'(NS_PER_SEC)));
  a_r5_plain_advance_sec: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_go && !step_go) |=>
      (time_sec == $past(time_sec)) || (time_sec == $past(time_sec) + SEC_W'(1)));
endmodule

// File: rtl/frac_tod_counter.sv
module frac_tod_counter
  import tod_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int QUO_W      = 8,
  parameter int FRAC_W     = 32,
  parameter int NS_W       = 30,
  parameter int SEC_W      = 48,
  parameter int NS_PER_SEC = 1000000000,
  parameter int RESET_QUO  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              cfg_err,
  output logic [NS_W-1:0]   time_ns,
  output logic [SEC_W-1:0]  time_sec
);
  logic              per_go, set_go, step_go;
  logic [QUO_W-1:0]  stg_quo;
  logic [FRAC_W-1:0] stg_num, stg_den;
  logic [NS_W-1:0]   stg_ns, stg_mag;
  logic [SEC_W-1:0]  stg_sec;
  logic              stg_neg;
  logic [QUO_W:0]    inc;

  tod_regfile #(
    .DATA_W(DATA_W), .QUO_W(QUO_W), .FRAC_W(FRAC_W),
    .NS_W(NS_W), .SEC_W(SEC_W), .RESET_QUO(RESET_QUO)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
    .addr(reg_addr), .wdata(reg_wdata),
    .time_ns(time_ns), .time_sec(time_sec),
    .per_go(per_go), .set_go(set_go), .step_go(step_go),
    .stg_quo(stg_quo), .stg_num(stg_num), .stg_den(stg_den),
    .stg_ns(stg_ns), .stg_sec(stg_sec), .stg_neg(stg_neg), .stg_mag(stg_mag),
    .rdata(reg_rdata)
  );

  tod_period_unit #(
    .QUO_W(QUO_W), .FRAC_W(FRAC_W), .RESET_QUO(RESET_QUO)
  ) u_period (
    .clk(clk), .rst_n(rst_n), .per_go(per_go),
    .stg_quo(stg_quo), .stg_num(stg_num), .stg_den(stg_den),
    .inc(inc), .cfg_err(cfg_err)
  );

  tod_time_core #(
    .QUO_W(QUO_W), .NS_W(NS_W), .SEC_W(SEC_W), .NS_PER_SEC(NS_PER_SEC)
  ) u_core (
    .clk(clk), .rst_n(rst_n), .inc(inc),
    .set_go(set_go), .stg_ns(stg_ns), .stg_sec(stg_sec),
    .step_go(step_go), .stg_neg(stg_neg), .stg_mag(stg_mag),
    .time_ns(time_ns), .time_sec(time_sec)
  );
endmodule

// File: tb/tb_frac_tod_counter.sv
`timescale 1ns/1ps
module tb_frac_tod_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cfg_err;
  logic [29:0] time_ns;
  logic [47:0] time_sec;

  frac_tod_counter dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_err(cfg_err), .time_ns(time_ns), .time_sec(time_sec)
  );

  always #4 clk = ~clk;

  localparam longint BILLION  = 1000000000;
  localparam longint SEC_MASK = (64'd1 << 48) - 1;

  int n_chk = 0, n_bad = 0;
  string cur_req = "R1";
  bit done = 0;

  // Behavioural reference state
  longint m_ns = 0, m_sec = 0, m_acc = 0, m_quo = 8, m_num = 0, m_den = 1;
  bit     m_err = 0;
  longint s_quo = 8, s_num = 0, s_den = 1, s_ns = 0, s_shi = 0, s_slo = 0, s_step = 0;
  longint snap = 0, e_rd = 0;
  bit     rd_due = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ns = 0; m_sec = 0; m_acc = 0; m_quo = 8; m_num = 0; m_den = 1; m_err = 0;
      s_quo = 8; s_num = 0; s_den = 1; s_ns = 0; s_shi = 0; s_slo = 0; s_step = 0;
      snap = 0; e_rd = 0; rd_due = 0;
    end else begin
      longint inc, v;
      bit     extra;
      rd_due = reg_rd;
      if (reg_rd) begin
        case (reg_addr)
          4'd10: begin e_rd = m_ns; snap = m_sec; end
          4'd11: e_rd = snap >> 32;
          4'd12: e_rd = snap & 64'hFFFF_FFFF;
          default: e_rd = 0;
        endcase
      end
      extra = (m_acc + m_num) >= m_den;
      inc = m_quo + (extra ? 1 : 0);
      if (reg_wr && reg_addr == 4'd7 && reg_wdata[0]) begin
        m_ns = s_ns; m_sec = (s_shi << 32) | s_slo;
      end else begin
        v = m_ns + inc;
        if (reg_wr && reg_addr == 4'd9 && reg_wdata[0]) begin
          if (s_step[31]) v = v - (s_step & 64'h3FFF_FFFF);
          else            v = v + (s_step & 64'h3FFF_FFFF);
        end
        while (v >= BILLION) begin v -= BILLION; m_sec += 1; end
        while (v < 0)        begin v += BILLION; m_sec -= 1; end
        m_ns = v;
        m_sec = m_sec & SEC_MASK;
      end
      m_acc = extra ? m_acc + m_num - m_den : m_acc + m_num;
      if (reg_wr && reg_addr == 4'd3 && reg_wdata[0]) begin
        if (s_den != 0 && s_num < s_den) begin
          m_quo = s_quo; m_num = s_num; m_den = s_den; m_acc = 0; m_err = 0;
        end else m_err = 1;
      end
      if (reg_wr) begin
        case (reg_addr)
          4'd0: s_quo = reg_wdata[7:0];
          4'd1: s_num = reg_wdata;
          4'd2: s_den = reg_wdata;
          4'd4: s_ns  = reg_wdata[29:0];
          4'd5: s_shi = reg_wdata[15:0];
          4'd6: s_slo = reg_wdata;
          4'd8: s_step = reg_wdata;
          default: ;
        endcase
      end
    end
  end

  // Compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      n_chk++;
      if (longint'(time_ns) != m_ns || longint'(time_sec) != m_sec) begin
        n_bad++;
        $display("FAIL %s time actual %0d.%0d expected %0d.%0d @%0t",
                 cur_req, time_sec, time_ns, m_sec, m_ns, $time);
      end
      n_chk++;
      if (cfg_err != m_err) begin
        n_bad++;
        $display("FAIL %s cfg_err actual %0b expected %0b @%0t", cur_req, cfg_err, m_err, $time);
      end
      if (rd_due) begin
        n_chk++;
        if (longint'(reg_rdata) != e_rd) begin
          n_bad++;
          $display("FAIL %s rdata actual %0h expected %0h @%0t", cur_req, reg_rdata, e_rd, $time);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_time(input logic [15:0] hi, input logic [31:0] lo, input logic [29:0] ns);
    wr(4'd4, {2'b0, ns});
    wr(4'd5, {16'b0, hi});
    wr(4'd6, lo);
    wr(4'd7, 32'd1);
  endtask

  task automatic finish_run();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired during %s", cur_req);
    finish_run();
  end

  initial begin
    cur_req = "R1";                       // reset values
    idle(3);
    @(negedge clk) rst_n = 1'b1;
    idle(5);

    cur_req = "R9";                       // live buses at default period
    idle(20);

    cur_req = "R3";                       // staged period has no effect yet
    wr(4'd0, 32'd2); wr(4'd1, 32'd500); wr(4'd2, 32'd1000);
    idle(4);
    wr(4'd3, 32'd0);                      // bit0 clear: ignored
    idle(4);
    wr(4'd3, 32'd1);                      // commit 2.5 ns
    cur_req = "R2";
    idle(20);
    wr(4'd0, 32'd6); wr(4'd1, 32'd1); wr(4'd2, 32'd3);
    wr(4'd3, 32'd1);                      // 6 1/3 ns
    idle(20);

    cur_req = "R4";                       // refused periods
    wr(4'd2, 32'd0); wr(4'd3, 32'd1);
    idle(5);
    wr(4'd1, 32'd5); wr(4'd2, 32'd5); wr(4'd3, 32'd1);
    idle(5);
    wr(4'd0, 32'd4); wr(4'd1, 32'd3); wr(4'd2, 32'd7); wr(4'd3, 32'd1);
    idle(10);

    cur_req = "R6";                       // absolute load
    set_time(16'h0000, 32'hFFFF_FFFF, 30'd999_999_950);
    cur_req = "R5";                       // carry into upper seconds
    idle(20);

    cur_req = "R7";                       // steps
    wr(4'd8, 32'd1234); wr(4'd9, 32'd1);
    idle(3);
    set_time(16'h0000, 32'd5, 30'd100);
    wr(4'd8, 32'h8000_03E8); wr(4'd9, 32'd1);           // -1000: single borrow
    idle(3);
    set_time(16'h0000, 32'd5, 30'd100);
    wr(4'd8, 32'hBFFF_FFFF); wr(4'd9, 32'd1);           // large negative: double borrow
    idle(3);
    set_time(16'h0000, 32'd9, 30'd999_999_000);
    wr(4'd8, 32'h3FFF_FFFF); wr(4'd9, 32'd1);           // large positive: double carry
    idle(3);

    cur_req = "R5";                       // seconds wrap both ways
    set_time(16'h0000, 32'd0, 30'd0);
    wr(4'd8, 32'h8000_0005); wr(4'd9, 32'd1);
    idle(3);
    set_time(16'hFFFF, 32'hFFFF_FFFF, 30'd999_999_990);
    idle(6);

    cur_req = "R8";                       // coherent reads
    set_time(16'h1234, 32'h89AB_CDEF, 30'd999_999_900);
    rd(4'd10);
    idle(30);
    rd(4'd11);
    rd(4'd12);
    rd(4'd3);
    rd(4'd15);
    idle(5);
    finish_run();
  end
endmodule